// File: doc/BRIEF.md
# Operand Address Generator for a Memory-Resident Register File

This unit resolves one operand specifier into an operand location for a processor whose general registers live in main memory. The specifier is a 2-bit mode and a 4-bit register number, together with a byte/word flag. The unit forms register addresses from a workspace base. It fetches register contents and the indexed-mode extension word through a single memory port. In autoincrement mode it writes the stepped register value back. It then reports either the register's own location or a memory effective address.

A sequencer issues `start_i` with the specifier, the workspace base and the current program counter. When `done_o` pulses, it takes `ea_o`, `is_reg_o` and the possibly advanced `pc_o`. Performing the operation on the operand is left to the caller.

Top module: `opnd_agen`

## Requirements
- R1: The specifier is `spec_i[5:4]` = mode and `spec_i[3:0]` = register number r. For mode 0, `is_reg_o`=1 and `ea_o` = the register's location. The port is not used, and `done_o` rises in the first cycle after the start edge.
- R2: For mode 1, `ea_o` is the word read from the register's location and `is_reg_o`=0. `done_o` comes 3 cycles after the start edge.
- R3: For mode 2 with r≠0, `ea_o` = extension word + register contents, modulo 2^16. The extension word is read at the latched program counter, and `done_o` comes after 5 cycles.
- R4: For mode 2 with r=0, `ea_o` equals the extension word and no register is read. `done_o` comes after 3 cycles.
- R5: For mode 3, `ea_o` is the register's prior contents. The register location is rewritten with contents+1 when `byte_i`=1, or contents+2 when `byte_i`=0, modulo 2^16. The write lands before `done_o`, which comes after 4 cycles.
- R6: A register's location is `wp_i` + 2·r, wrapping modulo 2^16.
- R7: `pc_o` is `pc_i`+2 (modulo 2^16) after a mode 2 operation, and `pc_i` otherwise.
- R8: `start_i` is ignored while `busy_o` is high. The running operation's results are unaffected.
- R9: `done_o` is a one-cycle pulse. `ea_o`, `is_reg_o` and `pc_o` hold their values until the next accepted start.
- R10: The port writes only in mode 3, and only once per operation. Read data is expected on `mem_rdata_i` in the cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin resolving a specifier (taken only when idle) |
| spec_i | input | 6 | Mode in [5:4], register number in [3:0] |
| byte_i | input | 1 | 1 = byte operand, 0 = word operand |
| wp_i | input | 16 | Workspace base byte address |
| pc_i | input | 16 | Address of the next instruction-stream word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| is_reg_o | output | 1 | Operand is the register itself |
| ea_o | output | 16 | Operand location (register location or memory address) |
| pc_o | output | 16 | Program counter after any extension fetch |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable for the request |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read request |

## Verification
The hardest cases are the wrap-around ones. One is a register location that wraps past the top of the address space. The other is an autoincrement that carries a register from 0xFFFF to 0 or 1. The sweep reaches both by placing the workspace at 0xFFF0, so registers 8–15 wrap to the bottom of memory, and by seeding register 15 with 0xFFFF. A start pulse issued mid-operation with a different specifier covers the ignore-while-busy rule. A program counter of 0xFFFE covers the extension-fetch wrap.

// File: rtl/opnd_agen_pkg.sv
package opnd_agen_pkg;
  typedef enum logic [1:0] {
    AM_REG  = 2'd0,
    AM_IND  = 2'd1,
    AM_IDX  = 2'd2,
    AM_AINC = 2'd3
  } am_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RREQ,
    ST_RLAT,
    ST_XREQ,
    ST_XLAT,
    ST_WB,
    ST_DONE
  } st_e;
endpackage

// File: rtl/opnd_agen_ctrl.sv
module opnd_agen_ctrl
  import opnd_agen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  am_e  mode_i,
  input  logic rzero_i,
  output st_e  st_o,
  output am_e  mode_o,
  output logic accept_o
);
  st_e st_q, st_d;
  am_e mode_q;

  assign accept_o = start_i && (st_q == ST_IDLE);
  assign st_o     = st_q;
  assign mode_o   = mode_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept_o) begin
        unique case (mode_i)
          AM_REG:  st_d = ST_DONE;
          AM_IDX:  st_d = rzero_i ? ST_XREQ : ST_RREQ;
          default: st_d = ST_RREQ;
        endcase
      end
      ST_RREQ: st_d = ST_RLAT;
      ST_RLAT: begin
        unique case (mode_q)
          AM_AINC: st_d = ST_WB;
          AM_IDX:  st_d = ST_XREQ;
          default: st_d = ST_DONE;
        endcase
      end
      ST_XREQ: st_d = ST_XLAT;
      ST_XLAT: st_d = ST_DONE;
      ST_WB:   st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= AM_REG;
    end else begin
      st_q <= st_d;
      if (accept_o) mode_q <= mode_i;
    end
  end

  // R4
  idx_abs_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && mode_i == AM_IDX && rzero_i) |=> (st_q == ST_XREQ));
endmodule

// File: rtl/opnd_agen_calc.sv
module opnd_agen_calc
  import opnd_agen_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  am_e           mode_i,
  input  logic [RW-1:0] rnum_i,
  input  logic          byte_i,
  input  logic [AW-1:0] wp_i,
  input  logic [AW-1:0] pc_i,
  input  st_e           st_i,
  input  am_e           mode_q_i,
  input  logic [AW-1:0] rdata_i,
  output logic [AW-1:0] reg_addr_o,
  output logic [AW-1:0] wdata_o,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] pc_o,
  output logic          is_reg_o,
  output logic          rzero_o
);
  logic [RW-1:0] rnum_q;
  logic          byte_q;
  logic [AW-1:0] wp_q, pc_q, regval_q, ea_q;
  logic          is_reg_q;

  function automatic logic [AW-1:0] loc(input logic [AW-1:0] wp, input logic [RW-1:0] r);
    return wp + {{(AW-RW-1){1'b0}}, r, 1'b0};
  endfunction

  assign rzero_o    = (rnum_i == '0);
  assign reg_addr_o = loc(wp_q, rnum_q);
  assign wdata_o    = regval_q + (byte_q ? AW'(1) : AW'(2));
  assign ea_o       = ea_q;
  assign pc_o       = pc_q;
  assign is_reg_o   = is_reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rnum_q   <= '0;
      byte_q   <= 1'b0;
      wp_q     <= '0;
      pc_q     <= '0;
      regval_q <= '0;
      ea_q     <= '0;
      is_reg_q <= 1'b0;
    end else if (accept_i) begin
      rnum_q   <= rnum_i;
      byte_q   <= byte_i;
      wp_q     <= wp_i;
      pc_q     <= pc_i;
      is_reg_q <= (mode_i == AM_REG);
      if (mode_i == AM_REG) ea_q <= loc(wp_i, rnum_i);
    end else begin
      if (st_i == ST_RLAT) begin
        regval_q <= rdata_i;
        if (mode_q_i != AM_IDX) ea_q <= rdata_i;
      end
      if (st_i == ST_XLAT) begin
        ea_q <= rdata_i + ((rnum_q == '0) ? '0 : regval_q);
        pc_q <= pc_q + AW'(2);
      end
    end
  end

  // R7
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_XLAT) |=> (pc_o == $past(pc_o) + AW'(2)));
endmodule

// File: rtl/opnd_agen.sv
module opnd_agen
  import opnd_agen_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [RW+1:0] spec_i,
  input  logic          byte_i,
  input  logic [AW-1:0] wp_i,
  input  logic [AW-1:0] pc_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          is_reg_o,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] pc_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_wdata_o,
  input  logic [AW-1:0] mem_rdata_i
);
  st_e           st;
  am_e           mode_q;
  am_e           mode_in;
  logic          accept, rzero;
  logic [AW-1:0] reg_addr, wdata, pc_cur;

  assign mode_in = am_e'(spec_i[RW+1:RW]);

  opnd_agen_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_in),
    .rzero_i  (rzero),
    .st_o     (st),
    .mode_o   (mode_q),
    .accept_o (accept)
  );

  opnd_agen_calc #(.AW(AW), .NREG(NREG)) u_calc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .mode_i     (mode_in),
    .rnum_i     (spec_i[RW-1:0]),
    .byte_i     (byte_i),
    .wp_i       (wp_i),
    .pc_i       (pc_i),
    .st_i       (st),
    .mode_q_i   (mode_q),
    .rdata_i    (mem_rdata_i),
    .reg_addr_o (reg_addr),
    .wdata_o    (wdata),
    .ea_o       (ea_o),
    .pc_o       (pc_cur),
    .is_reg_o   (is_reg_o),
    .rzero_o    (rzero)
  );

  assign pc_o        = pc_cur;
  assign busy_o      = (st != ST_IDLE);
  assign done_o      = (st == ST_DONE);
  assign mem_req_o   = (st == ST_RREQ) || (st == ST_XREQ) || (st == ST_WB);
  assign mem_we_o    = (st == ST_WB);
  assign mem_addr_o  = (st == ST_XREQ) ? pc_cur : reg_addr;
  assign mem_wdata_o = wdata;

  // R10
  we_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mode_q == AM_AINC));

  // R5
  wb_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == $past(mem_addr_o, 2)));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(ea_o) && $stable(pc_o) && $stable(is_reg_o)));

  // R1
  reg_noacc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_reg_o) |-> !$past(mem_req_o));

  // R8
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mode_q));
endmodule

// File: tb/opnd_agen_test.sv
module opnd_agen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  spec = '0;
  logic        byt = 1'b0;
  logic [15:0] wp = '0, pc = '0;
  logic        busy, done, is_reg, mem_req, mem_we;
  logic [15:0] ea, pc_out, mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [15:0] mem [256];
  int          wr_cnt = 0;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_agen uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .spec_i(spec), .byte_i(byt),
    .wp_i(wp), .pc_i(pc), .busy_o(busy), .done_o(done), .is_reg_o(is_reg),
    .ea_o(ea), .pc_o(pc_out), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[8:1]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      mem_rdata <= mem[mem_addr[8:1]];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rval(input int i, input logic [15:0] seed);
    return 16'(16'h1111 * i) + seed;
  endfunction

  task automatic run_case(input int mode, input int r, input bit b, input logic [15:0] w,
                          input logic [15:0] p, input logic [15:0] seed, input bit poke);
    logic [15:0] rv, ext, loc, exp_ea, exp_pc;
    int exp_lat, lat, w0;
    for (int i = 0; i < 16; i++) begin
      logic [15:0] a;
      a = w + 16'(2 * i);
      mem[a[8:1]] = rval(i, seed);
    end
    ext = 16'h0A50 ^ seed;
    mem[p[8:1]] = ext;
    rv  = rval(r, seed);
    loc = w + 16'(2 * r);
    exp_pc = p;
    unique case (mode)
      0: begin exp_ea = loc; exp_lat = 1; end
      1: begin exp_ea = rv;  exp_lat = 3; end
      2: begin exp_ea = ext + ((r == 0) ? 16'h0 : rv); exp_lat = (r == 0) ? 3 : 5; exp_pc = p + 16'd2; end
      default: begin exp_ea = rv; exp_lat = 4; end
    endcase
    @(negedge clk);
    start = 1'b1; spec = {2'(mode), 4'(r)}; byt = b; wp = w; pc = p;
    w0 = wr_cnt;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      if (poke && lat == 2) begin
        start = 1'b1; spec = 6'h00; wp = 16'h0000;
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk(done === 1'b1, "R9 done seen", 32'(done), 1);
    chk(lat == exp_lat, mode == 0 ? "R1 latency" : mode == 1 ? "R2 latency" :
        mode == 3 ? "R5 latency" : (r == 0 ? "R4 latency" : "R3 latency"), 32'(lat), 32'(exp_lat));
    chk(ea === exp_ea, poke ? "R8 ea after busy start" : mode == 0 ? "R1 R6 ea" : mode == 1 ? "R2 ea" :
        mode == 3 ? "R5 ea" : (r == 0 ? "R4 ea" : "R3 ea"), 32'(ea), 32'(exp_ea));
    chk(is_reg === (mode == 0), "R1 is_reg", 32'(is_reg), 32'(mode == 0));
    chk(pc_out === exp_pc, "R7 pc_o", 32'(pc_out), 32'(exp_pc));
    chk((wr_cnt - w0) == ((mode == 3) ? 1 : 0), "R10 write count", 32'(wr_cnt - w0), 32'(mode == 3));
    if (mode == 3)
      chk(mem[loc[8:1]] === rv + (b ? 16'd1 : 16'd2), "R5 write-back", 32'(mem[loc[8:1]]),
          32'(rv + (b ? 16'd1 : 16'd2)));
    else
      chk(mem[loc[8:1]] === rv, "R10 register untouched", 32'(mem[loc[8:1]]), 32'(rv));
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R9 done pulse", 32'({done, busy}), 0);
    chk(ea === exp_ea && pc_out === exp_pc, "R9 hold", 32'(ea), 32'(exp_ea));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R9 reset state",
        32'({busy, done, mem_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int cfg = 0; cfg < 2; cfg++)
      for (int m = 0; m < 4; m++)
        for (int r = 0; r < 16; r++)
          for (int b = 0; b < 2; b++)
            run_case(m, r, b[0], cfg == 0 ? 16'h0040 : 16'hFFF0,
                     cfg == 0 ? 16'hFFFE : 16'h0100, cfg == 0 ? 16'h0123 : 16'h0000, 1'b0);
    // R8: start pulses while busy are ignored
    run_case(2, 5, 1'b0, 16'h0040, 16'h0100, 16'h0321, 1'b1);
    run_case(3, 15, 1'b1, 16'hFFF0, 16'h0100, 16'h0000, 1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule